// File: doc/BRIEF.md
# Center-Aligned PWM Compare Unit

This block produces a set of pulse-width modulated outputs from one shared period counter. The counter runs in one of two modes. In edge-aligned mode it counts upward and wraps. In center-aligned mode it counts up to the period value and then back down. Each channel compares the count against its own compare value and switches its output between an idle level and the inverse of that level. Precedence rules fix the result when a compare hit falls on the same count as the counter's turning points.

Compare values and idle levels are never written straight into the working registers. Software first fills staging copies and then sets a request bit. The block copies all staged values in one step at the next legal counter event and then clears the request by itself. As a result, both the timing of the pulses and the idle polarities change only at known counter positions.

A fault input passes through a two-stage synchroniser and then sets a sticky fault flag. While the flag is set, the channels chosen by a mask are held at a safe level. Software clears the flag through the same write port once the fault input has returned low.

Top module: `pwm_ca_unit`

## Requirements
- R1: In edge-aligned mode (control bit 0 = 0) with the run bit (control bit 1) set, the count goes 0, 1, …, P and then back to 0, where P is the period register. `cnt_dir_o` stays 0. P must be at least 2.
- R2: In center-aligned mode (control bit 0 = 1) with run set, the count rises from 0 to P with `cnt_dir_o` = 0. It then falls from P−1 to 0 with `cnt_dir_o` = 1, and then rises again starting at 1.
- R3: A channel is active when the count equals its working compare value. In edge mode it becomes inactive when the count is at P. In center mode it becomes inactive on a compare hit while counting down, and also when the count is 0. The output is the idle level when the channel is inactive and its inverse when active. Each output is registered and appears one cycle after the count it was decided on.
- R4: In center mode, a compare hit at count 0 makes the channel active. This overrides the return to idle at zero.
- R5: A compare hit at count P makes the channel inactive, in both modes.
- R6: A pending request (command register bit 0) copies every staged compare value and idle level into the working registers. In edge mode the copy happens only at count P. In center mode it happens at count 0 and at count P. It happens only while run is set. The request then clears itself, so staging writes made after the copy wait for a new request.
- R7: A copied compare value is not used at the count where the copy happens, only from the next count onward. For example, staging 0 during a rise in center mode makes the copy happen at P. The coincident hit at 0 then follows at the next zero.
- R8: A copied idle level reaches the outputs in the same cycle as the copy.
- R9: The fault input is synchronised by two flip-flops and then sets the fault flag (`trap_o`), unless the fault-off switch (control bit 2) is 1. While the flag is set, each channel whose mask bit is 1 outputs its idle level if the idle-on-fault switch (control bit 3) is 1, and outputs 0 otherwise. Unmasked channels keep running normally.
- R10: The fault flag holds until a write of command bit 1 arrives while the synchronised fault input is 0. A clear issued while the fault is still present is ignored.
- R11: After reset, and whenever run is 0, the count, direction and channel states are 0 and `out_o` equals the working idle levels. The idle levels reset to 0.
- R12: The writable registers are selected by `wr_addr_i`: 0 control, 1 period, 2 fault mask, 3 staged idle levels, 4 command (bit 0 request copy, bit 1 clear fault), and 8+k the staged compare value of channel k. Writes take effect at the clock edge that samples `wr_en_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register select |
| wr_data_i | input | CNT_W | Write data |
| trap_i | input | 1 | Asynchronous fault input, active high |
| cnt_o | output | CNT_W | Period counter value |
| cnt_dir_o | output | 1 | Count direction, 1 = down |
| out_o | output | N_CH | PWM outputs |
| trap_o | output | 1 | Fault flag |

## Verification
A cycle-accurate reference model runs alongside the design and predicts count, direction, outputs and fault flag for every cycle. Edge mode with compare values inside the period, at 0 and at P separates the plain set/reset path from the coincidence rules. Center mode with the same values separates the R4 override from the R5 override. Compare and idle updates are requested before the counter starts, in mid-rise and in mid-fall, which shows whether a copy happens at the right turning point and whether the new compare value is wrongly applied to the copy cycle itself. Fault episodes are run with idle-on-fault set, with it cleared, with the fault function switched off, and with a clear issued while the fault is still held, to tell masked from unmasked channels and to show that the flag is sticky.

// File: rtl/pwm_ca_pkg.sv
package pwm_ca_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'h0;
  localparam logic [ADDR_W-1:0] A_PER   = 4'h1;
  localparam logic [ADDR_W-1:0] A_TMASK = 4'h2;
  localparam logic [ADDR_W-1:0] A_INIT  = 4'h3;
  localparam logic [ADDR_W-1:0] A_CMD   = 4'h4;
  localparam logic [ADDR_W-1:0] A_CMP0  = 4'h8;

  localparam int CMD_ARM = 0;
  localparam int CMD_CLR = 1;

  typedef struct packed {
    logic tinit;   // bit 3: trapped channels go to idle level
    logic tdis;    // bit 2: fault function off
    logic run;     // bit 1
    logic center;  // bit 0
  } ctrl_t;
endpackage

// File: rtl/pwm_ca_timer.sv
module pwm_ca_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_o,
  output logic             zm_o,
  output logic             pm_o,
  output logic             win_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;

  assign zm_o  = run_i && (cnt_q == '0);
  assign pm_o  = run_i && (cnt_q >= period_i);
  assign win_o = center_i ? (zm_o || pm_o) : pm_o;
  assign cnt_o = cnt_q;
  assign dir_o = dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else if (center_i) begin
      if (!dir_q) begin
        if (cnt_q >= period_i) begin
          dir_q <= 1'b1;
          cnt_q <= (cnt_q == '0) ? '0 : cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (cnt_q == '0) begin
        dir_q <= 1'b0;
        cnt_q <= CNT_W'(1);
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end else begin
      dir_q <= 1'b0;
      cnt_q <= (cnt_q >= period_i) ? '0 : cnt_q + 1'b1;
    end
  end

  p_edge_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !center_i && cnt_q >= period_i) |=> (cnt_q == '0));

  p_center_turn_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && center_i && dir_q && cnt_q == '0) |=> !dir_q);
endmodule

// File: rtl/pwm_ca_regs.sv
module pwm_ca_regs
  import pwm_ca_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int CNT_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [ADDR_W-1:0]          wr_addr_i,
  input  logic [CNT_W-1:0]           wr_data_i,
  input  logic                       win_i,
  output ctrl_t                      ctrl_o,
  output logic [CNT_W-1:0]           period_o,
  output logic [N_CH-1:0]            tmask_o,
  output logic [N_CH-1:0]            init_o,
  output logic [N_CH-1:0][CNT_W-1:0] cmp_o,
  output logic                       trap_clr_o,
  output logic                       xfer_o
);
  ctrl_t                      ctrl_q;
  logic [CNT_W-1:0]           period_q;
  logic [N_CH-1:0]            tmask_q, init_sh_q, init_q;
  logic [N_CH-1:0][CNT_W-1:0] cmp_sh_q, cmp_q;
  logic                       arm_q;
  logic                       cmd_wr, arm_wr;

  assign cmd_wr     = wr_en_i && (wr_addr_i == A_CMD);
  assign arm_wr     = cmd_wr && wr_data_i[CMD_ARM];
  assign trap_clr_o = cmd_wr && wr_data_i[CMD_CLR];
  assign xfer_o     = arm_q && win_i;

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
  assign tmask_o  = tmask_q;
  assign init_o   = init_q;
  assign cmp_o    = cmp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= '0;
      period_q  <= '0;
      tmask_q   <= '0;
      init_sh_q <= '0;
      init_q    <= '0;
      cmp_sh_q  <= '0;
      cmp_q     <= '0;
      arm_q     <= 1'b0;
    end else begin
      if (wr_en_i && wr_addr_i == A_CTRL)  ctrl_q    <= ctrl_t'(wr_data_i[3:0]);
      if (wr_en_i && wr_addr_i == A_PER)   period_q  <= wr_data_i;
      if (wr_en_i && wr_addr_i == A_TMASK) tmask_q   <= wr_data_i[N_CH-1:0];
      if (wr_en_i && wr_addr_i == A_INIT)  init_sh_q <= wr_data_i[N_CH-1:0];
      for (int k = 0; k < N_CH; k++) begin
        if (wr_en_i && wr_addr_i == A_CMP0 + ADDR_W'(k)) cmp_sh_q[k] <= wr_data_i;
      end
      // a fresh request written in the copy cycle survives
      if (arm_wr)      arm_q <= 1'b1;
      else if (xfer_o) arm_q <= 1'b0;
      if (xfer_o) begin
        cmp_q  <= cmp_sh_q;
        init_q <= init_sh_q;
      end
    end
  end

  p_arm_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_o && !arm_wr) |=> !arm_q);

  p_cmp_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_o |=> $stable(cmp_q));
endmodule

// File: rtl/pwm_ca_trap.sv
module pwm_ca_trap (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trap_i,
  input  logic tdis_i,
  input  logic clr_i,
  output logic flag_o
);
  logic s1_q, s2_q, flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      s1_q <= trap_i;
      s2_q <= s1_q;
      if (!tdis_i && s2_q)      flag_q <= 1'b1;
      else if (clr_i && !s2_q)  flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  p_trap_latency_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(trap_i, 2));

  p_trap_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && s2_q) |=> flag_q);
endmodule

// File: rtl/pwm_ca_chan.sv
module pwm_ca_chan #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             center_i,
  input  logic             dir_i,
  input  logic             zm_i,
  input  logic             pm_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             init_i,
  input  logic             trapped_i,
  input  logic             tinit_i,
  output logic             out_o
);
  logic cm, st_q, st_d;

  assign cm = run_i && (cnt_i == cmp_i);

  always_comb begin
    st_d = st_q;
    if (!run_i)              st_d = 1'b0;
    else if (center_i) begin
      if (cm && zm_i)        st_d = 1'b1;   // hit beats zero reset
      else if (cm && pm_i)   st_d = 1'b0;   // hit at top forces inactive
      else if (zm_i)         st_d = 1'b0;
      else if (cm)           st_d = !dir_i;
    end else begin
      if (pm_i)              st_d = 1'b0;
      else if (cm)           st_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= 1'b0;
    else         st_q <= st_d;
  end

  assign out_o = trapped_i ? (tinit_i & init_i) : (init_i ^ st_q);

  p_zero_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && center_i && zm_i && cm) |=> st_q);

  p_top_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && pm_i && cm) |=> !st_q);

  p_stopped_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> !st_q);
endmodule

// File: rtl/pwm_ca_unit.sv
module pwm_ca_unit
  import pwm_ca_pkg::*;
#(
  parameter int N_CH  = 3,
  parameter int CNT_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [3:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  input  logic              trap_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cnt_dir_o,
  output logic [N_CH-1:0]   out_o,
  output logic              trap_o
);
  ctrl_t                      ctrl;
  logic [CNT_W-1:0]           period;
  logic [N_CH-1:0]            tmask, init;
  logic [N_CH-1:0][CNT_W-1:0] cmp;
  logic                       trap_clr, xfer, flag;
  logic [CNT_W-1:0]           cnt;
  logic                       dir, zm, pm, win;

  pwm_ca_regs #(.N_CH(N_CH), .CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .win_i(win), .ctrl_o(ctrl), .period_o(period), .tmask_o(tmask),
    .init_o(init), .cmp_o(cmp), .trap_clr_o(trap_clr), .xfer_o(xfer)
  );

  pwm_ca_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .run_i(ctrl.run), .center_i(ctrl.center),
    .period_i(period), .cnt_o(cnt), .dir_o(dir), .zm_o(zm), .pm_o(pm),
    .win_o(win)
  );

  pwm_ca_trap u_trap (
    .clk_i, .rst_ni, .trap_i, .tdis_i(ctrl.tdis), .clr_i(trap_clr),
    .flag_o(flag)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    pwm_ca_chan #(.CNT_W(CNT_W)) u_chan (
      .clk_i, .rst_ni, .run_i(ctrl.run), .center_i(ctrl.center),
      .dir_i(dir), .zm_i(zm), .pm_i(pm), .cnt_i(cnt), .cmp_i(cmp[k]),
      .init_i(init[k]), .trapped_i(flag && tmask[k]),
      .tinit_i(ctrl.tinit), .out_o(out_o[k])
    );
  end

  assign cnt_o     = cnt;
  assign cnt_dir_o = dir;
  assign trap_o    = flag;

  p_init_copy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer |=> $stable(init));
endmodule

// File: tb/pwm_ca_unit_bench.sv
module pwm_ca_unit_bench;
  localparam int N = 3;
  localparam int W = 8;

  // R12 register map
  localparam logic [3:0] RA_CTRL = 4'h0, RA_PER = 4'h1, RA_MASK = 4'h2,
                         RA_INIT = 4'h3, RA_CMD = 4'h4, RA_CMP = 4'h8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [3:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic         trap = 1'b0;
  logic [W-1:0] cnt;
  logic         dir;
  logic [N-1:0] out;
  logic         trap_f;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_ca_unit #(.N_CH(N), .CNT_W(W)) u_pwm_ca_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .trap_i(trap), .cnt_o(cnt), .cnt_dir_o(dir),
    .out_o(out), .trap_o(trap_f)
  );

  typedef struct {
    logic [W-1:0] cnt;
    logic         dir;
    logic [N-1:0] out;
    logic         trap;
    string        t_cnt;
    string        t_out;
    string        t_trap;
  } exp_t;

  exp_t sb[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // reference model
  logic [W-1:0] m_cnt, m_per;
  logic         m_dir, m_center, m_run, m_tdis, m_tinit, m_arm;
  logic         m_s1, m_s2, m_flag, m_prev_x;
  logic [N-1:0] m_st, m_init, m_init_sh, m_mask;
  logic [W-1:0] m_cmp [N];
  logic [W-1:0] m_cmp_sh [N];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_per = '0; m_dir = 0; m_center = 0; m_run = 0;
      m_tdis = 0; m_tinit = 0; m_arm = 0; m_s1 = 0; m_s2 = 0;
      m_flag = 0; m_prev_x = 0; m_st = '0; m_init = '0; m_init_sh = '0;
      m_mask = '0;
      for (int k = 0; k < N; k++) begin m_cmp[k] = '0; m_cmp_sh[k] = '0; end
    end else begin
      exp_t e;
      logic zm, pm, x, anyc, zc, pc;
      logic [N-1:0] st_n;
      logic [W-1:0] cnt_n;
      logic dir_n, s2_old;
      zm = m_run && m_cnt == 0;
      pm = m_run && m_cnt == m_per;
      x = m_arm && m_run && (m_center ? (zm || pm) : pm);
      anyc = 0; zc = 0; pc = 0;
      st_n = m_st;
      for (int k = 0; k < N; k++) begin
        logic c;
        c = m_run && m_cnt == m_cmp[k];
        anyc |= c; zc |= c && zm; pc |= c && pm;
        if (!m_run) st_n[k] = 0;
        else if (m_center) begin
          if (c && zm) st_n[k] = 1;        // R4
          else if (c && pm) st_n[k] = 0;   // R5
          else if (zm) st_n[k] = 0;
          else if (c) st_n[k] = !m_dir;
        end else begin
          if (pm) st_n[k] = 0;
          else if (c) st_n[k] = 1;
        end
      end
      cnt_n = m_cnt; dir_n = m_dir;
      if (!m_run) begin cnt_n = 0; dir_n = 0; end
      else if (m_center) begin
        if (!m_dir) begin
          if (m_cnt == m_per) begin dir_n = 1; cnt_n = m_cnt - 1; end
          else cnt_n = m_cnt + 1;
        end else if (m_cnt == 0) begin dir_n = 0; cnt_n = 1; end
        else cnt_n = m_cnt - 1;
      end else begin
        dir_n = 0;
        cnt_n = (m_cnt == m_per) ? 0 : m_cnt + 1;
      end
      s2_old = m_s2;
      if (!m_tdis && s2_old) m_flag = 1;
      else if (wr_en && wr_addr == RA_CMD && wr_data[1] && !s2_old) m_flag = 0;
      m_s2 = m_s1; m_s1 = trap;
      if (x) begin
        for (int k = 0; k < N; k++) m_cmp[k] = m_cmp_sh[k];
        m_init = m_init_sh;
        m_arm = 0;
      end
      if (wr_en) begin
        case (wr_addr)
          RA_CTRL: begin
            m_center = wr_data[0]; m_run = wr_data[1];
            m_tdis = wr_data[2]; m_tinit = wr_data[3];
          end
          RA_PER:  m_per = wr_data;
          RA_MASK: m_mask = wr_data[N-1:0];
          RA_INIT: m_init_sh = wr_data[N-1:0];
          RA_CMD:  if (wr_data[0]) m_arm = 1;
          default: if (wr_addr >= RA_CMP && wr_addr < RA_CMP + N)
                     m_cmp_sh[wr_addr - RA_CMP] = wr_data;
        endcase
      end
      m_cnt = cnt_n; m_dir = dir_n; m_st = st_n;
      for (int k = 0; k < N; k++)
        e.out[k] = (m_flag && m_mask[k]) ? (m_tinit & m_init[k])
                                         : (m_init[k] ^ m_st[k]);
      e.cnt = m_cnt; e.dir = m_dir; e.trap = m_flag;
      e.t_cnt  = m_center ? "R2" : "R1";
      e.t_trap = m_tdis ? "R9" : "R10";
      if (m_flag && (m_mask != 0)) e.t_out = "R9";
      else if (x)                  e.t_out = "R6/R8";
      else if (m_prev_x)           e.t_out = "R7";
      else if (zc)                 e.t_out = "R4";
      else if (pc)                 e.t_out = "R5";
      else if (!m_run)             e.t_out = "R11";
      else                         e.t_out = "R3";
      m_prev_x = x;
      sb.push_back(e);
    end
  end

  // monitor
  always @(negedge clk) begin
    while (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      chk(cnt == e.cnt, e.t_cnt, "count", cnt, e.cnt);
      chk(dir == e.dir, "R2", "direction", dir, e.dir);
      chk(out == e.out, e.t_out, "outputs", out, e.out);
      chk(trap_f == e.trap, e.t_trap, "fault flag", trap_f, e.trap);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(cnt == 0 && dir == 0, "R11", "count after reset", cnt, 0);
    chk(out == 0, "R11", "outputs after reset", out, 0);
    chk(trap_f == 0, "R11", "flag after reset", trap_f, 0);

    wr(RA_PER, 6);
    wr(RA_CMP + 0, 2);
    wr(RA_CMP + 1, 0);
    wr(RA_CMP + 2, 6);            // hit at top: R5
    wr(RA_INIT, 3'b100);
    wr(RA_CMD, 1);                // request while stopped: held (R6)
    idle(3);
    chk(out == 0, "R6", "no copy while stopped", out, 0);
    wr(RA_CTRL, 4'b0010);         // edge mode run: R1, R3
    idle(30);
    wr(RA_CMP + 0, 4); wr(RA_CMD, 1);
    idle(20);
    wr(RA_INIT, 3'b010); wr(RA_CMD, 1);  // R8
    idle(16);
    wr(RA_CTRL, 4'b0011);         // center mode: R2, R4
    idle(30);
    idle(2);
    wr(RA_CMP + 0, 0); wr(RA_CMD, 1);    // R7
    idle(40);
    wr(RA_CMP + 0, 3); wr(RA_CMP + 2, 6); wr(RA_CMD, 1);
    idle(30);
    wr(RA_CMP + 1, 5);
    idle(30);                     // no request: staging must not copy (R6)
    wr(RA_CMD, 1);
    idle(30);

    // fault, idle-on-fault set: R9, R10
    wr(RA_MASK, 3'b011);
    wr(RA_CTRL, 4'b1011);
    @(negedge clk); trap = 1;
    idle(6);
    wr(RA_CMD, 2);                // ignored, fault still present
    idle(4);
    chk(trap_f == 1, "R10", "flag kept during fault", trap_f, 1);
    trap = 0;
    idle(4);
    chk(trap_f == 1, "R10", "flag sticky", trap_f, 1);
    wr(RA_CMD, 3);                // clear and request at once
    idle(4);
    chk(trap_f == 0, "R10", "flag cleared", trap_f, 0);

    // fault, masked outputs forced low
    wr(RA_CTRL, 4'b0011);
    trap = 1; idle(8); trap = 0; idle(3);
    wr(RA_CMD, 2); idle(3);

    // fault function off
    wr(RA_CTRL, 4'b0111);
    trap = 1; idle(8);
    chk(trap_f == 0, "R9", "fault off ignores input", trap_f, 0);
    trap = 0; idle(3);

    wr(RA_CTRL, 4'b0000);
    idle(3);
    chk(cnt == 0 && dir == 0, "R11", "stopped count", cnt, 0);
    idle(2);
    done = 1;
    report();
  end
endmodule